// File: doc/BRIEF.md
# Floating-point status and control register

This block holds the floating-point unit's status and control word. The word carries a two-bit rounding-mode code, a denormal-handling bit, five enable bits, five sticky flags and six per-operation cause bits. Five of the cause bits cover the arithmetic exception kinds: inexact, underflow, overflow, divide-by-zero and invalid. The sixth cause bit records an unsupported-operand error.

When the arithmetic unit reports a completed operation, the five arithmetic cause bits take that operation's exception indications. The matching flags accumulate them and stay set. The operand screening stage has its own strobe, which sets the error cause. The block decodes the rounding-mode code into a registered rounding choice for the datapath. Software can overwrite the writable fields through a write port and read the whole word back. A trap request is raised whenever an enabled cause, or the error cause, is set.

Top module: `fpsr_ctl`

## Requirements
- R1: A synchronous active-high reset clears every field, so the read word is zero. After reset the decoded rounding output selects round-to-nearest-even (`rnd_rtz`=0) and `trap_req` is low.
- R2: On `op_done`, cause bits [16:12] are loaded with `op_exc`, whose bit order is inexact (bit 0), underflow, overflow, divide-by-zero, invalid (bit 4). Any bit not raised is cleared. The new value is visible in the cycle after the strobe.
- R3: On `op_done`, flag bits [6:2] (same order) become the old flags ORed with `op_exc`. A completion never clears a flag.
- R4: The divide-by-zero position, `op_exc[3]`, is the infinite-result-from-finite-operands indication. It drives cause bit 15 and flag bit 5.
- R5: `screen_err` sets the error cause at bit 17. A completion neither sets nor clears that bit.
- R6: Writing rounding code 00 to bits [1:0] gives `rnd_rtz`=0 (nearest-even). Code 01 gives `rnd_rtz`=1 (toward zero). The change appears in the cycle after the write.
- R7: Rounding codes 10 and 11 leave `rnd_rtz` at its previous value. Bits [1:0] still read back the written code.
- R8: A software write replaces rounding code [1:0], flags [6:2], enables [11:7], causes [17:12] and denormal mode (bit 18). Bits [31:19] always read zero.
- R9: When a software write and `op_done` fall in the same cycle, the completion decides cause bits [16:12] and flag bits [6:2]. The write still sets every other field.
- R10: `trap_req` is high when any cause bit in [16:12] is set together with its enable bit in [11:7], or when the error cause at bit 17 is set.
- R11: `rnd_rtz_eff` is high whenever `cvt_trunc` is high, whatever the rounding code. Otherwise it equals `rnd_rtz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | DATA_W | Software write data |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | N_EXC | Exception indications of the completed operation |
| screen_err | input | 1 | Operand-screen error strobe |
| cvt_trunc | input | 1 | Current operation is a float-to-integer truncation |
| csr_rdata | output | DATA_W | Register read value |
| rnd_rtz | output | 1 | Decoded rounding: 1 toward zero, 0 nearest-even |
| rnd_rtz_eff | output | 1 | Rounding choice after the truncation override |
| trap_req | output | 1 | Enabled exception pending |

## Verification
The bench builds the block with its defaults: a 32-bit word and five exception kinds. These defaults put the error cause at bit 17 and the denormal bit at 18, so every field position named in the requirements is exercised as written. With these values the bench can drive the write/completion collision and the undefined rounding codes after both defined codes. It can also check the read-as-zero upper bits directly against a written word that has bit 31 set.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int RM_W = 2;
  typedef enum logic {RND_NEAR_EVEN = 1'b0, RND_TO_ZERO = 1'b1} rnd_e;
endpackage

// File: rtl/fpsr_rm_decode.sv
module fpsr_rm_decode
  import fpsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [RM_W-1:0] code,
  output rnd_e            mode_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= RND_NEAR_EVEN;
    else if (load) begin
      case (code)
        2'b00:   mode_q <= RND_NEAR_EVEN;
        2'b01:   mode_q <= RND_TO_ZERO;
        default: mode_q <= mode_q;
      endcase
    end
  end
endmodule

// File: rtl/fpsr_exc_bank.sv
module fpsr_exc_bank #(
  parameter int N_EXC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_wr,
  input  logic [N_EXC-1:0] sw_flags,
  input  logic [N_EXC-1:0] sw_causes,
  input  logic             done,
  input  logic [N_EXC-1:0] exc,
  output logic [N_EXC-1:0] flags_q,
  output logic [N_EXC-1:0] causes_q
);
  for (genvar i = 0; i < N_EXC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q[i]  <= 1'b0;
        causes_q[i] <= 1'b0;
      end else if (done) begin
        causes_q[i] <= exc[i];
        flags_q[i]  <= flags_q[i] | exc[i];
      end else if (sw_wr) begin
        causes_q[i] <= sw_causes[i];
        flags_q[i]  <= sw_flags[i];
      end
    end
  end
endmodule

// File: rtl/fpsr_ctl.sv
module fpsr_ctl
  import fpsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_EXC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              op_done,
  input  logic [N_EXC-1:0]  op_exc,
  input  logic              screen_err,
  input  logic              cvt_trunc,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              rnd_rtz,
  output logic              rnd_rtz_eff,
  output logic              trap_req
);
  localparam int FLAG_LSB  = RM_W;
  localparam int EN_LSB    = FLAG_LSB + N_EXC;
  localparam int CAUSE_LSB = EN_LSB + N_EXC;
  localparam int ERR_BIT   = CAUSE_LSB + N_EXC;
  localparam int DN_BIT    = ERR_BIT + 1;

  logic [RM_W-1:0]  rm_q;
  logic [N_EXC-1:0] en_q, flags_q, causes_q;
  logic             err_q, dn_q;
  rnd_e             mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rm_q  <= '0;
      en_q  <= '0;
      dn_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (sw_wr) begin
        rm_q <= sw_wdata[RM_W-1:0];
        en_q <= sw_wdata[EN_LSB +: N_EXC];
        dn_q <= sw_wdata[DN_BIT];
      end
      if (screen_err)  err_q <= 1'b1;
      else if (sw_wr)  err_q <= sw_wdata[ERR_BIT];
    end
  end

  fpsr_exc_bank #(.N_EXC(N_EXC)) u_bank (
    .clk(clk), .rst(rst), .sw_wr(sw_wr),
    .sw_flags(sw_wdata[FLAG_LSB +: N_EXC]),
    .sw_causes(sw_wdata[CAUSE_LSB +: N_EXC]),
    .done(op_done), .exc(op_exc),
    .flags_q(flags_q), .causes_q(causes_q)
  );

  fpsr_rm_decode u_rm (
    .clk(clk), .rst(rst), .load(sw_wr),
    .code(sw_wdata[RM_W-1:0]), .mode_q(mode_q)
  );

  always_comb begin
    csr_rdata                         = '0;
    csr_rdata[RM_W-1:0]               = rm_q;
    csr_rdata[FLAG_LSB +: N_EXC]      = flags_q;
    csr_rdata[EN_LSB +: N_EXC]        = en_q;
    csr_rdata[CAUSE_LSB +: N_EXC]     = causes_q;
    csr_rdata[ERR_BIT]                = err_q;
    csr_rdata[DN_BIT]                 = dn_q;
  end

  assign rnd_rtz     = (mode_q == RND_TO_ZERO);
  assign rnd_rtz_eff = rnd_rtz | cvt_trunc;
  assign trap_req    = err_q | (|(causes_q & en_q));
endmodule

// File: rtl/fpsr_ctl_chk.sv
module fpsr_ctl_chk #(
  parameter int DATA_W = 32,
  parameter int N_EXC  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_wr,
  input logic [DATA_W-1:0] sw_wdata,
  input logic              op_done,
  input logic [N_EXC-1:0]  op_exc,
  input logic              screen_err,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              rnd_rtz,
  input logic              trap_req
);
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + N_EXC;
  localparam int CAUSE_LSB = EN_LSB + N_EXC;
  localparam int ERR_BIT   = CAUSE_LSB + N_EXC;

  // R2
  cause_load_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |=> csr_rdata[CAUSE_LSB +: N_EXC] == $past(op_exc));
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> (csr_rdata[FLAG_LSB +: N_EXC] & $past(csr_rdata[FLAG_LSB +: N_EXC]))
               == $past(csr_rdata[FLAG_LSB +: N_EXC]));
  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    screen_err |=> csr_rdata[ERR_BIT]);
  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr && !screen_err) |=> csr_rdata[ERR_BIT] == $past(csr_rdata[ERR_BIT]));
  // R7
  rm_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_wdata[1]) |=> $stable(rnd_rtz));
  // R10
  trap_err_chk: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[ERR_BIT] |-> trap_req);
endmodule

bind fpsr_ctl fpsr_ctl_chk #(.DATA_W(DATA_W), .N_EXC(N_EXC)) u_chk (
  .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
  .op_done(op_done), .op_exc(op_exc), .screen_err(screen_err),
  .csr_rdata(csr_rdata), .rnd_rtz(rnd_rtz), .trap_req(trap_req)
);

// File: tb/fpsr_ctl_test.sv
module fpsr_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_exc = '0;
  logic        screen_err = 1'b0;
  logic        cvt_trunc = 1'b0;
  logic [31:0] csr_rdata;
  logic        rnd_rtz, rnd_rtz_eff, trap_req;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpsr_ctl uut (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .op_done(op_done), .op_exc(op_exc), .screen_err(screen_err),
    .cvt_trunc(cvt_trunc), .csr_rdata(csr_rdata), .rnd_rtz(rnd_rtz),
    .rnd_rtz_eff(rnd_rtz_eff), .trap_req(trap_req)
  );

  function automatic logic [31:0] word(logic [1:0] rm, logic [4:0] fl, logic [4:0] en,
                                       logic [4:0] ca, logic er, logic dn);
    return {13'd0, dn, er, ca, en, fl, rm};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic complete(logic [4:0] e);
    op_done = 1'b1; op_exc = e;
    step();
    op_done = 1'b0; op_exc = '0;
  endtask

  task automatic swrite(logic [31:0] w);
    sw_wr = 1'b1; sw_wdata = w;
    step();
    sw_wr = 1'b0; sw_wdata = '0;
  endtask

  task automatic t_reset();
    chk("R1 word", csr_rdata, 32'h0);
    chk("R1 rtz", {31'd0, rnd_rtz}, 32'd0);
    chk("R1 trap", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_completion();
    complete(5'b00101);
    chk("R2 cause load", csr_rdata, word(2'b00, 5'b00101, 5'b0, 5'b00101, 1'b0, 1'b0));
    complete(5'b01000);
    chk("R4 divzero bits", csr_rdata, word(2'b00, 5'b01101, 5'b0, 5'b01000, 1'b0, 1'b0));
    complete(5'b00000);
    chk("R3 flags sticky", csr_rdata, word(2'b00, 5'b01101, 5'b0, 5'b00000, 1'b0, 1'b0));
  endtask

  task automatic t_screen();
    screen_err = 1'b1; step(); screen_err = 1'b0;
    chk("R5 err set", {31'd0, csr_rdata[17]}, 32'd1);
    chk("R10 err trap", {31'd0, trap_req}, 32'd1);
    complete(5'b00001);
    chk("R5 err kept", csr_rdata, word(2'b00, 5'b01101, 5'b0, 5'b00001, 1'b1, 1'b0));
  endtask

  task automatic t_write();
    swrite(32'h8000_0000 | word(2'b01, 5'b0, 5'b11111, 5'b0, 1'b0, 1'b1));
    chk("R8 write word", csr_rdata, word(2'b01, 5'b0, 5'b11111, 5'b0, 1'b0, 1'b1));
    chk("R6 rtz on 01", {31'd0, rnd_rtz}, 32'd1);
    chk("R10 no trap", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_rm_undef();
    swrite(word(2'b10, 5'b0, 5'b0, 5'b0, 1'b0, 1'b0));
    chk("R7 keep after 10", {31'd0, rnd_rtz}, 32'd1);
    chk("R7 code readback", {30'd0, csr_rdata[1:0]}, 32'd2);
    swrite(word(2'b00, 5'b0, 5'b0, 5'b0, 1'b0, 1'b0));
    chk("R6 rtz on 00", {31'd0, rnd_rtz}, 32'd0);
    swrite(word(2'b11, 5'b0, 5'b0, 5'b0, 1'b0, 1'b0));
    chk("R7 keep after 11", {31'd0, rnd_rtz}, 32'd0);
  endtask

  task automatic t_collide();
    swrite(word(2'b00, 5'b00001, 5'b0, 5'b0, 1'b0, 1'b0));
    sw_wr = 1'b1; sw_wdata = word(2'b01, 5'b11111, 5'b00100, 5'b11111, 1'b0, 1'b1);
    op_done = 1'b1; op_exc = 5'b00010;
    step();
    sw_wr = 1'b0; sw_wdata = '0; op_done = 1'b0; op_exc = '0;
    chk("R9 collision", csr_rdata, word(2'b01, 5'b00011, 5'b00100, 5'b00010, 1'b0, 1'b1));
  endtask

  task automatic t_trap();
    complete(5'b00100);
    chk("R10 enabled cause", {31'd0, trap_req}, 32'd1);
    complete(5'b00001);
    chk("R10 disabled cause", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_trunc();
    swrite(word(2'b00, 5'b0, 5'b0, 5'b0, 1'b0, 1'b0));
    cvt_trunc = 1'b1; #1;
    chk("R11 trunc override", {31'd0, rnd_rtz_eff}, 32'd1);
    cvt_trunc = 1'b0; #1;
    chk("R11 no override", {31'd0, rnd_rtz_eff}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_completion();
    t_screen();
    t_write();
    t_rm_undef();
    t_collide();
    t_trap();
    t_trunc();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule